// File: doc/BRIEF.md
# I2C Multi-Channel Interrupt Hub

This block gathers interrupt events from a set of I2C bus channels (14 by default) and merges them into one interrupt line for the controller. Each channel owns a 15-bit interrupt-enable register and a 15-bit write-one-to-clear status register. A global register holds one pending bit per channel. The protocol engines stay outside this block. They signal events as single-cycle pulses, one bit per flag, and they report whether a receive command is still pending.

Enable masking destroys flags rather than hiding them. Whenever an event arrives for a channel, the updated status is ANDed with that channel's enable register, so every disabled flag is lost, including ones that were already set. When software clears the receive-done flag (bit 2) while the channel still has a receive pending, the hub sends that channel a one-cycle re-arm request so it fetches the next byte.

The block decodes a 4 KB register window. Slot 0 (0x000–0x03F) is global. Each channel then has a 64-byte slot, and the slots skip a 256-byte hole at 0x200–0x2FF.

Top module: `i2c_irq_hub`

## Requirements
- R1: In a cycle where a channel receives any event pulse, its next status is (old status, after any same-cycle clear, OR event bits) AND its current enable register, so that set flags which are disabled are discarded.
- R2: A write to a channel's status register (channel offset 0x10) clears each status bit in 14:0 whose write-data bit is 1, and leaves the other bits unchanged.
- R3: A write to a channel's enable register (channel offset 0x0C) stores write-data bits 14:0. The register reads back with bits 31:15 zero.
- R4: The global register reads at address 0x000 with bit i equal to channel i's pending bit and the upper bits zero. A channel's pending bit is set by an event update that leaves its status nonzero. It is cleared by a status write that leaves its status zero. Otherwise it holds. Writes anywhere in 0x000–0x03F change nothing.
- R5: The interrupt output is registered. In each cycle it equals the OR of all global pending bits as they stood in the previous cycle.
- R6: Channel i (i < 7) occupies base 0x40·(i+1), and channel i (i ≥ 7) occupies base 0x40·(i+5). No channel responds in 0x200–0x2FF, and writes there change nothing.
- R7: A status write with data bit 2 = 1, issued while status bit 2 is set and the channel's receive-pending input is high, raises that channel's re-arm output for exactly the next cycle. In every other case the re-arm output stays low.
- R8: After synchronous reset, all enable, status and global bits are zero, and the interrupt and re-arm outputs are low.
- R9: A read of any address other than the global register and the channels' enable and status registers returns 0xFFFFFFFF.
- R10: When a status clear and an event reach the same channel in the same cycle, the clear is applied first, then the events are ORed in, then the enable mask is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address within the window, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_pulse | input | 210 | Event pulses, 15 bits per channel, channel i at bits [15i+14:15i] |
| rx_pending | input | 14 | Per-channel flag: a receive command is still outstanding |
| rearm_req | output | 14 | Per-channel one-cycle request to run the next receive |
| irq | output | 1 | Merged interrupt line |

## Verification
A corrupted status or enable register shows up at reg_rdata as soon as the channel is read. It also shows up on irq when the channel's pending bit goes wrong. The global bit reaches irq one cycle after the faulty update. A lost or spurious re-arm is visible on rearm_req in the cycle right after the status write, so a missed pulse cannot be covered up by later traffic. Decode faults appear as reads of all ones where a register should be, or as writes to the hole or global slot that alter a channel.

// File: rtl/i2c_irq_hub_pkg.sv
// Package: shared constants and the slot mapping for the interrupt hub.
// Assumes a 64-byte slot per channel and one contiguous gap of unused slots.
package i2c_irq_hub_pkg;
    localparam int FLAG_W     = 15;   // implemented status/enable bits
    localparam int RXDONE_BIT = 2;    // receive-done flag position
    localparam logic [5:0] OFS_ENABLE = 6'h0C;
    localparam logic [5:0] OFS_STATUS = 6'h10;

    // Slot index (address / 64) of a channel.
    function automatic int chan_slot(input int ch, input int split, input int gap);
        return (ch < split) ? ch + 1 : ch + 1 + gap;
    endfunction
endpackage

// File: rtl/i2c_irq_addr_dec.sv
// Address decoder: maps a window byte address onto the global register
// and the per-channel enable/status registers.
// Assumes word-aligned accesses; the low two address bits take part in the match.
module i2c_irq_addr_dec
    import i2c_irq_hub_pkg::*;
#(
    parameter int NCH    = 14,
    parameter int ADDR_W = 12,
    parameter int SPLIT  = 7,
    parameter int GAP    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glob_hit,
    output logic [NCH-1:0]    en_sel,
    output logic [NCH-1:0]    st_sel
);
    localparam int SLOT_W = ADDR_W - 6;

    logic [SLOT_W-1:0] slot;
    logic [5:0]        ofs;

    assign slot     = addr[ADDR_W-1:6];
    assign ofs      = addr[5:0];
    assign glob_hit = (addr == '0);

    // One comparator pair per channel on its slot number.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(chan_slot(i, SPLIT, GAP));
        assign en_sel[i] = (slot == MY_SLOT) && (ofs == OFS_ENABLE);
        assign st_sel[i] = (slot == MY_SLOT) && (ofs == OFS_STATUS);
    end

    // R6
    always_comb begin
        dec_onehot_chk: assert ($onehot0({en_sel, st_sel}) || $isunknown(addr));
    end
endmodule

// File: rtl/i2c_irq_chan.sv
// Channel slice: enable register, write-1-to-clear status with destructive
// masking on events, the channel's global pending bit and the re-arm pulse.
// Assumes events are single-cycle pulses from the channel's bus engine.
module i2c_irq_chan
    import i2c_irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              en_sel,
    input  logic              st_sel,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [FLAG_W-1:0] evt,
    input  logic              rx_pend,
    output logic [FLAG_W-1:0] en_q,
    output logic [FLAG_W-1:0] st_q,
    output logic              glob_q,
    output logic              rearm_q
);
    logic              en_wr, st_wr, evt_any;
    logic [FLAG_W-1:0] st_cleared, st_next;

    assign en_wr   = wr_en && en_sel;
    assign st_wr   = wr_en && st_sel;
    assign evt_any = |evt;

    // Clear first, merge events, then mask on events.
    always_comb begin
        st_cleared = st_wr ? (st_q & ~wdata) : st_q;
        st_next    = evt_any ? ((st_cleared | evt) & en_q) : st_cleared;
    end

    // Register update for enable, status, pending bit and re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            st_q    <= '0;
            glob_q  <= 1'b0;
            rearm_q <= 1'b0;
        end else begin
            if (en_wr) en_q <= wdata;
            st_q <= st_next;
            if (st_wr && (st_next == '0))
                glob_q <= 1'b0;
            else if (evt_any && (st_next != '0))
                glob_q <= 1'b1;
            rearm_q <= st_wr && wdata[RXDONE_BIT] && st_q[RXDONE_BIT] && rx_pend;
        end
    end

    // R1
    evt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any |=> ((st_q & ~$past(en_q)) == '0));
    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !evt_any) |=> ((st_q & $past(wdata)) == '0));
    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata[RXDONE_BIT] && st_q[RXDONE_BIT] && rx_pend) |=> rearm_q);
    // R4
    glob_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_q) |-> (st_q != '0));
endmodule

// File: rtl/i2c_irq_merge.sv
// Merge stage: registers the OR of all channel pending bits onto the
// shared interrupt line. Assumes the pending bits are registered upstream.
module i2c_irq_merge #(
    parameter int NCH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] glob,
    output logic           irq_q
);
    // Registered wide OR.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |glob;
    end

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|glob) |=> irq_q);
    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob == '0) |=> !irq_q);
endmodule

// File: rtl/i2c_irq_hub.sv
// Top: I2C multi-channel interrupt hub. Decodes the register window, hosts one
// slice per channel, merges the pending bits and returns read data.
// Assumes single-cycle register writes and combinational reads.
module i2c_irq_hub
    import i2c_irq_hub_pkg::*;
#(
    parameter int NCH    = 14,
    parameter int ADDR_W = 12,
    parameter int SPLIT  = 7,
    parameter int GAP    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NCH*FLAG_W-1:0] evt_pulse,
    input  logic [NCH-1:0]        rx_pending,
    output logic [NCH-1:0]        rearm_req,
    output logic                  irq
);
    logic              glob_hit;
    logic [NCH-1:0]    en_sel, st_sel, glob;
    logic [FLAG_W-1:0] en_arr [NCH];
    logic [FLAG_W-1:0] st_arr [NCH];

    i2c_irq_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W), .SPLIT(SPLIT), .GAP(GAP)) u_dec (
        .addr    (reg_addr),
        .glob_hit(glob_hit),
        .en_sel  (en_sel),
        .st_sel  (st_sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        i2c_irq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_wr),
            .en_sel (en_sel[i]),
            .st_sel (st_sel[i]),
            .wdata  (reg_wdata[FLAG_W-1:0]),
            .evt    (evt_pulse[i*FLAG_W +: FLAG_W]),
            .rx_pend(rx_pending[i]),
            .en_q   (en_arr[i]),
            .st_q   (st_arr[i]),
            .glob_q (glob[i]),
            .rearm_q(rearm_req[i])
        );
    end

    i2c_irq_merge #(.NCH(NCH)) u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .glob (glob),
        .irq_q(irq)
    );

    // Read mux; unmapped addresses return all ones.
    always_comb begin
        reg_rdata = '1;
        if (glob_hit) reg_rdata = {{(32-NCH){1'b0}}, glob};
        for (int i = 0; i < NCH; i++) begin
            if (en_sel[i]) reg_rdata = {{(32-FLAG_W){1'b0}}, en_arr[i]};
            if (st_sel[i]) reg_rdata = {{(32-FLAG_W){1'b0}}, st_arr[i]};
        end
    end

    // R8
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && rearm_req == '0));
endmodule

// File: tb/tb_i2c_irq_hub.sv
module tb_i2c_irq_hub;
    localparam int NCH = 14;
    localparam int FW  = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH*FW-1:0] evt_pulse = '0;
    logic [NCH-1:0]  rx_pending = '0;
    logic [NCH-1:0]  rearm_req;
    logic            irq;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [FW-1:0]  m_en [NCH];
    logic [FW-1:0]  m_st [NCH];
    logic [NCH-1:0] m_gl;
    logic           m_irq;
    logic [NCH-1:0] m_rearm;

    always #5 clk = ~clk;

    i2c_irq_hub dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .rx_pending(rx_pending), .rearm_req(rearm_req), .irq(irq)
    );

    function automatic logic [11:0] base_of(int ch);
        return 12'((ch < 7 ? ch + 1 : ch + 5) * 64);
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h000) return {18'b0, m_gl};
        for (int c = 0; c < NCH; c++) begin
            if (a == base_of(c) + 12'h00C) return {17'b0, m_en[c]};
            if (a == base_of(c) + 12'h010) return {17'b0, m_st[c]};
        end
        return 32'hFFFF_FFFF;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin m_en[c] = '0; m_st[c] = '0; end
        m_gl = '0; m_irq = 0; m_rearm = '0;
    endtask

    // One clock: drive inputs, advance model, compare clocked outputs.
    task automatic step(bit wr, logic [11:0] a, logic [31:0] d,
                        logic [NCH*FW-1:0] ev, logic [NCH-1:0] rx);
        logic [FW-1:0] nst;
        logic [FW-1:0] evc;
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev; rx_pending = rx;
        m_irq = |m_gl;
        for (int c = 0; c < NCH; c++) begin
            bit ew = wr && (a == base_of(c) + 12'h00C);
            bit sw = wr && (a == base_of(c) + 12'h010);
            evc = ev[c*FW +: FW];
            m_rearm[c] = sw && d[2] && m_st[c][2] && rx[c];
            nst = (m_st[c] & ~(sw ? d[FW-1:0] : '0)) | evc;
            if (evc != '0) nst = nst & m_en[c];
            if (sw && nst == '0) m_gl[c] = 0;
            else if (evc != '0 && nst != '0) m_gl[c] = 1;
            m_st[c] = nst;
            if (ew) m_en[c] = d[FW-1:0];
        end
        @(posedge clk); @(negedge clk);
        chk("R5 irq", {31'b0, irq}, {31'b0, m_irq});
        chk("R7 rearm", {18'b0, rearm_req}, {18'b0, m_rearm});
        reg_wr = 0; evt_pulse = '0;
    endtask

    task automatic rd(string tag, logic [11:0] a);
        reg_wr = 0; reg_addr = a; #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic sweep(string tag);
        rd({tag, " R4 global"}, 12'h000);
        for (int c = 0; c < NCH; c++) begin
            rd({tag, " R3 enable"}, base_of(c) + 12'h00C);
            rd({tag, " R1 R2 status"}, base_of(c) + 12'h010);
        end
    endtask

    function automatic logic [NCH*FW-1:0] ev1(int ch, logic [FW-1:0] v);
        logic [NCH*FW-1:0] r = '0;
        r[ch*FW +: FW] = v;
        return r;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 irq after reset", {31'b0, irq}, 32'd0);
        chk("R8 rearm after reset", {18'b0, rearm_req}, 32'd0);
        sweep("R8 reset");

        // R3: only bits 14:0 kept
        step(1, base_of(3) + 12'h00C, 32'hFFFF_FFFF, '0, '0);
        rd("R3 enable mask", base_of(3) + 12'h00C);
        // R1/R4/R5: event raises status, global and irq
        step(0, 0, 0, ev1(3, 15'h0020), '0);
        rd("R1 status set", base_of(3) + 12'h010);
        rd("R4 global set", 12'h000);
        step(0, 0, 0, '0, '0);
        chk("R5 irq high", {31'b0, irq}, 32'd1);
        // R1 destructive mask
        step(1, base_of(3) + 12'h00C, 32'h4, '0, '0);
        step(0, 0, 0, ev1(3, 15'h0004), '0);
        rd("R1 destructive mask", base_of(3) + 12'h010);
        // R7 rearm on RX-done clear with pending receive
        step(1, base_of(3) + 12'h010, 32'h4, '0, 14'h0008);
        chk("R7 rearm pulse", {18'b0, rearm_req}, 32'h8);
        rd("R4 global cleared", 12'h000);
        step(0, 0, 0, '0, 14'h0008);
        chk("R7 rearm one cycle", {18'b0, rearm_req}, 32'h0);
        step(0, 0, 0, '0, '0);
        chk("R5 irq low", {31'b0, irq}, 32'd0);
        // R7: no rearm when bit 2 already clear
        step(1, base_of(3) + 12'h010, 32'h4, '0, 14'h3FFF);
        // R6: high channels and hole
        step(1, base_of(7) + 12'h00C, 32'h7FFF, '0, '0);
        step(1, base_of(13) + 12'h00C, 32'h1234, '0, '0);
        rd("R6 chan7 base 0x300", 12'h30C);
        rd("R6 chan13 base 0x480", 12'h48C);
        step(1, 12'h20C, 32'hFFFF_FFFF, '0, '0);
        step(1, 12'h210, 32'hFFFF_FFFF, '0, '0);
        rd("R6 R9 hole read", 12'h20C);
        // R4: global slot writes ignored
        step(0, 0, 0, ev1(7, 15'h0101), '0);
        step(1, 12'h000, 32'h0, '0, '0);
        step(1, 12'h010, 32'hFFFF_FFFF, '0, '0);
        sweep("R6 R4 after ignored writes");
        // R10: clear and event same cycle
        step(1, base_of(7) + 12'h010, 32'h0101, ev1(7, 15'h0100), '0);
        rd("R10 clear then event", base_of(7) + 12'h010);
        // R9 unmapped
        rd("R9 global slot ofs", 12'h004);
        rd("R9 command ofs", base_of(2) + 12'h014);
        rd("R9 past last slot", 12'h4D0);
        rd("R9 top", 12'hFFC);

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [NCH*FW-1:0] ev = '0;
            int c = $urandom_range(NCH - 1);
            int k = $urandom_range(9);
            logic [11:0] a;
            for (int j = 0; j < NCH; j++)
                if ($urandom_range(7) == 0) ev[j*FW +: FW] = 15'($urandom & $urandom);
            case (k)
                0, 1:    a = base_of(c) + 12'h00C;
                2, 3, 4: a = base_of(c) + 12'h010;
                5:       a = 12'($urandom_range(63)) & 12'hFFC;
                6:       a = 12'h200 + (12'($urandom_range(255)) & 12'hFFC);
                default: a = 12'($urandom) & 12'hFFC;
            endcase
            step($urandom_range(1) == 1, a, $urandom, ev, 14'($urandom));
            if (n % 100 == 99) sweep("rand");
            if (n == 1500) begin
                rst_n = 0; model_reset();
                @(posedge clk); @(negedge clk);
                rst_n = 1;
                sweep("R8 mid reset");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule